// File: doc/BRIEF.md
# Fetch Thread Selector for a Four-Thread Simultaneous Multithreading Core

This block decides, every cycle, which of four hardware threads the front end should fetch from. For each thread it keeps a count of instructions currently in flight. The count goes up by the number of instructions fetched for that thread and down by the number retired or squashed. Among the threads allowed to fetch, the selector picks the one with the lowest count. This steers fetch bandwidth toward threads that are draining the machine quickly and away from threads that are clogging it.

The block also supports a sleep-on-address mechanism so that spin-waiting threads stop using fetch slots. A thread first arms a watch on a memory address, then issues a quiesce command. From the next cycle it is no longer scheduled. It becomes schedulable again when a store to the same 8-byte block is observed. That store also disarms the watch. A quiesce from a thread with no armed watch does nothing.

The output is a thread number with a valid flag. The flag is low when every thread is asleep. The selection is computed from registered state, so inputs in one cycle affect the choice made in the following cycle.

Top module: `smt_fetch_pick`

## Requirements
- R1: After reset, every in-flight count is zero, no thread is armed or asleep, and the output is `sel_valid`=1 with `sel_tid`=0 (thread 0 has first priority).
- R2: On each clock edge, a thread's count becomes its old value plus `fetch_n`, minus `retire_n` and `squash_n` for that thread. The selection reflects the new count in the cycle after the stimulus.
- R3: The selected thread has the smallest in-flight count among all threads that are not asleep.
- R4: Among eligible threads with equal counts, the winner is the first one met when scanning upward (with wraparound) from the thread after the last granted thread. The last granted thread is updated only in cycles with `sel_valid`=1.
- R5: A count saturates at 31 (2^CNT_W−1) instead of wrapping, and it decrements normally from the saturated value.
- R6: A count never goes below zero. A decrement larger than the current value plus the fetch amount yields zero.
- R7: With `cmd_valid`=1, `cmd_op`=0 arms thread `cmd_tid` on the block `cmd_addr[31:3]` and wakes it. `cmd_op`=1 puts an armed thread to sleep, and from the next cycle it is excluded from selection.
- R8: A store with `st_valid`=1 whose `st_addr[31:3]` equals an armed thread's watched block wakes and disarms that thread; address bits [2:0] are ignored. A store to any other block leaves the thread asleep.
- R9: A quiesce (`cmd_op`=1) to a thread that is not armed, including one just disarmed by a wake-up, is ignored, and the thread stays eligible.
- R10: When every thread is asleep, `sel_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_n | input | NUM_THR x FETCH_W | Instructions fetched this cycle, per thread |
| retire_n | input | NUM_THR x FETCH_W | Instructions retired this cycle, per thread |
| squash_n | input | NUM_THR x FETCH_W | Instructions squashed this cycle, per thread |
| cmd_valid | input | 1 | Watch command present |
| cmd_op | input | 1 | 0 = arm watch, 1 = quiesce |
| cmd_tid | input | TID_W | Thread the command applies to |
| cmd_addr | input | ADDR_W | Address to watch (used by arm) |
| st_valid | input | 1 | Observed store present |
| st_addr | input | ADDR_W | Address of the observed store |
| sel_valid | output | 1 | A thread is selected for fetch |
| sel_tid | output | TID_W | Selected thread number |

## Verification
Every result of this block appears exactly one clock edge after its stimulus. Count updates, arm, quiesce, wake-up and the round-robin pointer are all registered, and the selection is a combinational function of that registered state. The bench therefore applies a stimulus just after a falling edge, lets one rising edge pass, and samples `sel_valid` and `sel_tid` at the next falling edge, before it drives anything new. The same-cycle inputs cannot affect the sampled output, so each expected value follows from the state the bench itself tracks from the requirements.

// File: rtl/smtsel_pkg.sv
// Shared constants and command encoding for the fetch thread selector.
// Assumes: byte addresses; watch granularity fixed at 8-byte blocks.
package smtsel_pkg;

    // Low address bits ignored when matching a watched block.
    localparam int unsigned WATCH_LSB = 3;

    // Watch command encoding carried on cmd_op.
    typedef enum logic {
        CMD_ARM     = 1'b0,
        CMD_QUIESCE = 1'b1
    } watch_cmd_e;

endpackage

// File: rtl/smtsel_inflight.sv
// Per-thread in-flight instruction counter.
// Adds the fetched amount, removes retired and squashed amounts, and
// clamps the result to [0, 2^CNT_W-1]. Assumes all three inputs are
// valid every cycle (zero when idle).
module smtsel_inflight #(
    parameter int FETCH_W = 3,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FETCH_W-1:0] add_n,
    input  logic [FETCH_W-1:0] ret_n,
    input  logic [FETCH_W-1:0] sq_n,
    output logic [CNT_W-1:0]   count_o
);

    localparam int SUM_W = CNT_W + FETCH_W + 2;
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

    logic [CNT_W-1:0] count_q;
    logic [SUM_W-1:0] up_sum;
    logic [SUM_W-1:0] down_sum;
    logic [SUM_W-1:0] diff;
    logic [CNT_W-1:0] count_d;

    // Compute the clamped next count.
    always_comb begin
        up_sum   = SUM_W'(count_q) + SUM_W'(add_n);
        down_sum = SUM_W'(ret_n) + SUM_W'(sq_n);
        diff     = up_sum - down_sum;
        if (down_sum > up_sum) begin
            count_d = '0;
        end else if (diff > CNT_MAX) begin
            count_d = CNT_MAX[CNT_W-1:0];
        end else begin
            count_d = diff[CNT_W-1:0];
        end
    end

    // Hold the count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/smtsel_watch.sv
// Per-thread address watch and sleep state.
// An arm records the block tag and wakes the thread. A matching store
// wakes and disarms it. A quiesce puts the thread to sleep only if it is armed.
// Priority within one cycle: arm, then store match, then quiesce.
module smtsel_watch #(
    parameter int TAG_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             quiesce_i,
    input  logic [TAG_W-1:0] arm_tag_i,
    input  logic             snoop_v_i,
    input  logic [TAG_W-1:0] snoop_tag_i,
    output logic             armed_o,
    output logic             asleep_o
);

    logic             armed_q;
    logic             asleep_q;
    logic [TAG_W-1:0] tag_q;
    logic             hit;

    // Detect a store to the watched block.
    assign hit = snoop_v_i && armed_q && (snoop_tag_i == tag_q);

    // Update the armed, sleep and tag state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            asleep_q <= 1'b0;
            tag_q    <= '0;
        end else if (arm_i) begin
            armed_q  <= 1'b1;
            asleep_q <= 1'b0;
            tag_q    <= arm_tag_i;
        end else if (hit) begin
            armed_q  <= 1'b0;
            asleep_q <= 1'b0;
        end else if (quiesce_i && armed_q) begin
            asleep_q <= 1'b1;
        end
    end

    assign armed_o  = armed_q;
    assign asleep_o = asleep_q;

endmodule

// File: rtl/smtsel_picker.sv
// Least-count thread picker with a rotating tie-break.
// Scans the threads from the one after the last grant, keeping the first
// strictly smaller count, so equal counts go to the earliest thread in
// rotated order. The grant pointer moves only when a thread is picked.
module smtsel_picker #(
    parameter int NUM_THR = 4,
    parameter int CNT_W   = 5,
    parameter int TID_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_THR-1:0][CNT_W-1:0] cnt_i,
    input  logic [NUM_THR-1:0]            elig_i,
    output logic                          sel_valid_o,
    output logic [TID_W-1:0]              sel_tid_o
);

    logic [TID_W-1:0] last_q;
    logic [TID_W-1:0] scan_idx;
    logic [TID_W-1:0] best_tid;
    logic [CNT_W-1:0] best_cnt;
    logic             found;

    // Rotated scan for the smallest eligible count.
    always_comb begin
        found    = 1'b0;
        best_tid = '0;
        best_cnt = '1;
        scan_idx = '0;
        for (int k = 0; k < NUM_THR; k++) begin
            scan_idx = TID_W'((int'(last_q) + 1 + k) % NUM_THR);
            if (elig_i[scan_idx] && (!found || (cnt_i[scan_idx] < best_cnt))) begin
                found    = 1'b1;
                best_tid = scan_idx;
                best_cnt = cnt_i[scan_idx];
            end
        end
    end

    // Remember the last granted thread.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= TID_W'(NUM_THR - 1);
        end else if (found) begin
            last_q <= best_tid;
        end
    end

    assign sel_valid_o = found;
    assign sel_tid_o   = best_tid;

endmodule

// File: rtl/smt_fetch_pick.sv
// Top of the fetch thread selector.
// Decodes watch commands per thread, builds one counter and one watch
// unit per thread, and feeds the awake threads to the picker.
// Assumes at most one watch command and one observed store per cycle.
module smt_fetch_pick
    import smtsel_pkg::*;
#(
    parameter  int NUM_THR = 4,
    parameter  int FETCH_W = 3,
    parameter  int CNT_W   = 5,
    parameter  int ADDR_W  = 32,
    localparam int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_THR-1:0][FETCH_W-1:0] fetch_n,
    input  logic [NUM_THR-1:0][FETCH_W-1:0] retire_n,
    input  logic [NUM_THR-1:0][FETCH_W-1:0] squash_n,
    input  logic                            cmd_valid,
    input  logic                            cmd_op,
    input  logic [TID_W-1:0]                cmd_tid,
    input  logic [ADDR_W-1:0]               cmd_addr,
    input  logic                            st_valid,
    input  logic [ADDR_W-1:0]               st_addr,
    output logic                            sel_valid,
    output logic [TID_W-1:0]                sel_tid
);

    localparam int TAG_W = ADDR_W - WATCH_LSB;

    logic [NUM_THR-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_THR-1:0]            armed;
    logic [NUM_THR-1:0]            sleeping;
    logic [NUM_THR-1:0]            arm_vec;
    logic [NUM_THR-1:0]            quiesce_vec;
    logic [TAG_W-1:0]              arm_tag;
    logic [TAG_W-1:0]              st_tag;
    logic                          unused_low_bits;

    // Drop the in-block offset bits from both addresses.
    assign arm_tag         = cmd_addr[ADDR_W-1:WATCH_LSB];
    assign st_tag          = st_addr[ADDR_W-1:WATCH_LSB];
    assign unused_low_bits = ^{cmd_addr[WATCH_LSB-1:0], st_addr[WATCH_LSB-1:0]};

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        // Route the command to its thread.
        assign arm_vec[g]     = cmd_valid && (cmd_op == CMD_ARM) && (cmd_tid == TID_W'(g));
        assign quiesce_vec[g] = cmd_valid && (cmd_op == CMD_QUIESCE) && (cmd_tid == TID_W'(g));

        smtsel_inflight #(
            .FETCH_W (FETCH_W),
            .CNT_W   (CNT_W)
        ) i_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_n   (fetch_n[g]),
            .ret_n   (retire_n[g]),
            .sq_n    (squash_n[g]),
            .count_o (cnt_all[g])
        );

        smtsel_watch #(
            .TAG_W (TAG_W)
        ) i_watch (
            .clk         (clk),
            .rst_n       (rst_n),
            .arm_i       (arm_vec[g]),
            .quiesce_i   (quiesce_vec[g]),
            .arm_tag_i   (arm_tag),
            .snoop_v_i   (st_valid),
            .snoop_tag_i (st_tag),
            .armed_o     (armed[g]),
            .asleep_o    (sleeping[g])
        );
    end

    smtsel_picker #(
        .NUM_THR (NUM_THR),
        .CNT_W   (CNT_W),
        .TID_W   (TID_W)
    ) i_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt_all),
        .elig_i      (~sleeping),
        .sel_valid_o (sel_valid),
        .sel_tid_o   (sel_tid)
    );

endmodule

// File: rtl/smt_fetch_pick_chk.sv
// Assertion checker for smt_fetch_pick, attached through bind.
// Observes the per-thread counts and watch state next to the selection.
module smt_fetch_pick_chk
    import smtsel_pkg::*;
#(
    parameter int NUM_THR = 4,
    parameter int FETCH_W = 3,
    parameter int CNT_W   = 5,
    parameter int TID_W   = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_THR-1:0][FETCH_W-1:0] fetch_n,
    input logic [NUM_THR-1:0][FETCH_W-1:0] retire_n,
    input logic [NUM_THR-1:0][FETCH_W-1:0] squash_n,
    input logic                            cmd_valid,
    input logic                            cmd_op,
    input logic [TID_W-1:0]                cmd_tid,
    input logic [NUM_THR-1:0][CNT_W-1:0]   cnt_all,
    input logic [NUM_THR-1:0]              armed,
    input logic [NUM_THR-1:0]              sleeping,
    input logic                            sel_valid,
    input logic [TID_W-1:0]                sel_tid
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    AST_PICK_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> !sleeping[sel_tid]);  // R7

    AST_NONE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (&sleeping) |-> !sel_valid);  // R10

    for (genvar t = 0; t < NUM_THR; t++) begin : g_chk
        AST_PICK_MIN: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_valid && !sleeping[t]) |-> (cnt_all[sel_tid] <= cnt_all[t]));  // R3

        AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt_all[t] == CMAX) && (retire_n[t] == '0) && (squash_n[t] == '0))
            |=> (cnt_all[t] == CMAX));  // R5

        AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt_all[t] == '0) && (fetch_n[t] == '0)) |=> (cnt_all[t] == '0));  // R6

        AST_QUIESCE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && (cmd_op == CMD_QUIESCE) && (cmd_tid == TID_W'(t)) && !armed[t])
            |=> !sleeping[t]);  // R9
    end

endmodule

bind smt_fetch_pick smt_fetch_pick_chk #(
    .NUM_THR (NUM_THR),
    .FETCH_W (FETCH_W),
    .CNT_W   (CNT_W),
    .TID_W   (TID_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_n   (fetch_n),
    .retire_n  (retire_n),
    .squash_n  (squash_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_tid   (cmd_tid),
    .cnt_all   (cnt_all),
    .armed     (armed),
    .sleeping  (sleeping),
    .sel_valid (sel_valid),
    .sel_tid   (sel_tid)
);

// File: tb/test_smt_fetch_pick.sv
// Self-checking bench: a vector table for count and tie-break behaviour,
// then directed tests for reset, sleep, wake and saturation.
module test_smt_fetch_pick;

    localparam int NT = 4;
    localparam int FW = 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NT-1:0][FW-1:0]   fetch_n = '0;
    logic [NT-1:0][FW-1:0]   retire_n = '0;
    logic [NT-1:0][FW-1:0]   squash_n = '0;
    logic                    cmd_valid = 1'b0;
    logic                    cmd_op = 1'b0;
    logic [1:0]              cmd_tid = '0;
    logic [31:0]             cmd_addr = '0;
    logic                    st_valid = 1'b0;
    logic [31:0]             st_addr = '0;
    logic                    sel_valid;
    logic [1:0]              sel_tid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    smt_fetch_pick i_smt_fetch_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_n   (fetch_n),
        .retire_n  (retire_n),
        .squash_n  (squash_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_tid   (cmd_tid),
        .cmd_addr  (cmd_addr),
        .st_valid  (st_valid),
        .st_addr   (st_addr),
        .sel_valid (sel_valid),
        .sel_tid   (sel_tid)
    );

    // Row: fetch[38:27] retire[26:15] squash[14:3] exp_valid[2] exp_tid[1:0]
    // Per-thread fields are {t3,t2,t1,t0}.
    localparam logic [38:0] VEC [0:8] = '{
        {3'd0,3'd0,3'd0,3'd4, 12'd0,                12'd0,                1'b1, 2'd1},
        {3'd0,3'd0,3'd3,3'd0, 12'd0,                12'd0,                1'b1, 2'd2},
        {3'd0,3'd2,3'd0,3'd0, 12'd0,                12'd0,                1'b1, 2'd3},
        {3'd5,3'd0,3'd0,3'd0, 12'd0,                12'd0,                1'b1, 2'd2},
        {3'd0,3'd2,3'd0,3'd0, 3'd0,3'd0,3'd0,3'd4,  12'd0,                1'b1, 2'd0},
        {3'd0,3'd0,3'd0,3'd1, 12'd0,                3'd7,3'd0,3'd0,3'd0,  1'b1, 2'd3},
        {3'd1,3'd0,3'd0,3'd0, 3'd0,3'd0,3'd2,3'd0,  12'd0,                1'b1, 2'd0},
        {12'd0,               12'd0,                12'd0,                1'b1, 2'd1},
        {12'd0,               12'd0,                12'd0,                1'b1, 2'd3}
    };

    function automatic logic [NT-1:0][FW-1:0] one(input int t, input int n);
        one = '0;
        one[t] = FW'(n);
    endfunction

    // Compare the outputs with the expected selection.
    task automatic chk(input string req, input logic ev, input logic [1:0] et);
        checks++;
        if (sel_valid !== ev || (ev && sel_tid !== et)) begin
            errors++;
            $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
                     req, sel_valid, sel_tid, ev, et);
        end
    endtask

    // Drive one cycle of stimulus after a falling edge; return at the next falling edge.
    task automatic apply(input logic [NT-1:0][FW-1:0] f, input logic [NT-1:0][FW-1:0] r,
                         input logic [NT-1:0][FW-1:0] s, input logic cv, input logic op,
                         input logic [1:0] ct, input logic [31:0] ca,
                         input logic sv, input logic [31:0] sa);
        fetch_n = f; retire_n = r; squash_n = s;
        cmd_valid = cv; cmd_op = op; cmd_tid = ct; cmd_addr = ca;
        st_valid = sv; st_addr = sa;
        @(posedge clk);
        @(negedge clk);
        fetch_n = '0; retire_n = '0; squash_n = '0;
        cmd_valid = 1'b0; st_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        chk("R1 reset", 1'b1, 2'd0);

        // Vector table: counts, clamping at zero, rotating ties.
        for (int i = 0; i < 9; i++) begin
            logic [38:0] row;
            row = VEC[i];
            apply(row[38:27], row[26:15], row[14:3], 1'b0, 1'b0, 2'd0, 32'd0, 1'b0, 32'd0);
            chk($sformatf("R2 R3 R4 R6 row %0d", i), row[2], row[1:0]);
        end

        // R9: quiesce without an arm is ignored.
        do_reset();
        apply(one(1,1) | one(2,1) | one(3,1), '0, '0, 1'b1, 1'b1, 2'd0, 32'h0, 1'b0, 32'h0);
        chk("R9 quiesce unarmed", 1'b1, 2'd0);

        // R7 and R8: arm, sleep, wrong-block store, matching store.
        do_reset();
        apply(one(1,1) | one(2,1) | one(3,1), '0, '0, 1'b1, 1'b0, 2'd0, 32'h100, 1'b0, 32'h0);
        apply('0, '0, '0, 1'b1, 1'b1, 2'd0, 32'h0, 1'b0, 32'h0);
        chk("R7 sleeping thread skipped", 1'b1, 2'd1);
        apply('0, '0, '0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 32'h108);
        chk("R8 other block keeps sleep", 1'b1, 2'd2);
        apply('0, '0, '0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 32'h105);
        chk("R8 matching store wakes", 1'b1, 2'd0);
        apply('0, '0, '0, 1'b1, 1'b1, 2'd0, 32'h0, 1'b0, 32'h0);
        chk("R9 wake disarms", 1'b1, 2'd0);

        // R10: all threads asleep, then one woken.
        for (int t = 0; t < NT; t++)
            apply('0, '0, '0, 1'b1, 1'b0, 2'(t), 32'h200 + 32'(t) * 32'h100, 1'b0, 32'h0);
        for (int t = 0; t < NT; t++) begin
            apply('0, '0, '0, 1'b1, 1'b1, 2'(t), 32'h0, 1'b0, 32'h0);
            if (t == 2) chk("R7 last awake thread", 1'b1, 2'd3);
        end
        chk("R10 none eligible", 1'b0, 2'd0);
        apply('0, '0, '0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 32'h600);
        chk("R10 unrelated store", 1'b0, 2'd0);
        apply('0, '0, '0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 32'h304);
        chk("R8 wake thread 1", 1'b1, 2'd1);

        // R5: saturation at 31 seen against a count of 30.
        do_reset();
        apply('0, '0, '0, 1'b1, 1'b0, 2'd2, 32'h40, 1'b0, 32'h0);
        apply('0, '0, '0, 1'b1, 1'b0, 2'd3, 32'h80, 1'b0, 32'h0);
        apply('0, '0, '0, 1'b1, 1'b1, 2'd2, 32'h0, 1'b0, 32'h0);
        apply('0, '0, '0, 1'b1, 1'b1, 2'd3, 32'h0, 1'b0, 32'h0);
        for (int c = 0; c < 6; c++) begin
            int f0;
            f0 = (c < 4) ? 7 : ((c == 4) ? 2 : 0);
            apply(one(1,7) | one(0,f0), '0, '0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 32'h0);
        end
        chk("R5 saturated count", 1'b1, 2'd0);
        apply('0, one(1,7), one(1,7), 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 32'h0);
        chk("R5 decrement from saturation", 1'b1, 2'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule